// File: doc/BRIEF.md
# Four-Lane Vector Element Adder

This block holds a small bank of vector registers and runs one element-wise addition at a time, producing dst[i] = srcA[i] + srcB[i] for every index below the active vector length. The work is split across four adder lanes. Lane k owns the indices congruent to k modulo four. Each lane starts one addition per cycle, so one group of four elements enters the pipeline on every cycle. Each lane adder is a fixed two-stage pipeline, and its result is written back into the destination register.

A host first fills the registers through a write port and reads them back through a combinational read port. It then selects two source registers, a destination register and a length, and pulses start. While the operation runs, busy stays high. A one-cycle done pulse marks the cycle after the last element is written. Destination indices at or above the length keep their old contents. The destination may name either source register, or both.

Top module: `vadd4_unit`

## Requirements
- R1: After reset, busy and done are both low.
- R2: While busy is low, a cycle with host_we high writes host_wdata into element host_idx of register host_reg. host_rdata always shows that element combinationally.
- R3: For every index i below the effective length, the destination element becomes srcA[i] + srcB[i], truncated to 64 bits (two's-complement wraparound).
- R4: Destination elements at or above the effective length are left unchanged. The effective length is vlen, but any vlen above 64 counts as 64.
- R5: Four elements, one per lane, enter the adders on each cycle. With an effective length L > 0, done is high in the cycle after clock edge ceil(L/4)+2. Edges are counted from the edge that samples start, which is edge 0.
- R6: With an effective length of 0, no register changes, busy stays low, and done is high in the cycle right after the edge that samples start.
- R7: busy is high from the edge that samples start until done rises, and it is low whenever done is high. done lasts exactly one cycle.
- R8: While busy is high, start and host_we are ignored. The running operation, its timing and all register contents are unaffected by them.
- R9: The destination may equal either source or both, and the result is then the same as if the sources had been copied first.
- R10: Registers other than the destination are unchanged by an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| start | input | 1 | Begins an operation when busy is low |
| src_a | input | 3 | First source register number |
| src_b | input | 3 | Second source register number |
| dst | input | 3 | Destination register number |
| vlen | input | 7 | Requested vector length (values above 64 count as 64) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last write-back |
| host_we | input | 1 | Host element write enable (ignored while busy) |
| host_reg | input | 3 | Host register number |
| host_idx | input | 6 | Host element index |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Element selected by host_reg and host_idx |

## Verification
Full-length operations exercise every lane in every group. Lengths of 1, 5 and 63 leave a partial last group, which shows whether each lane gates on its own index and not on the group as a whole. Zero and over-range lengths test the length clamp and the early-done path. Operands near 2^64 separate true wraparound from carry leaks. Operations whose destination equals one or both sources show whether write-back can corrupt operands that are still being read. Random register and length choices, plus start and host-write pulses injected mid-operation, check that nothing outside the destination's active range moves.

// File: rtl/vadd4_unit.sv
module vadd4_unit #(
  parameter int ELEM_W = 64,
  parameter int NREG   = 8,
  parameter int MAX_VL = 64,
  parameter int LANES  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(NREG)-1:0]       src_a,
  input  logic [$clog2(NREG)-1:0]       src_b,
  input  logic [$clog2(NREG)-1:0]       dst,
  input  logic [$clog2(MAX_VL+1)-1:0]   vlen,
  output logic                          busy,
  output logic                          done,
  input  logic                          host_we,
  input  logic [$clog2(NREG)-1:0]       host_reg,
  input  logic [$clog2(MAX_VL)-1:0]     host_idx,
  input  logic [ELEM_W-1:0]             host_wdata,
  output logic [ELEM_W-1:0]             host_rdata
);
  localparam int RW     = $clog2(NREG);
  localparam int IW     = $clog2(MAX_VL);
  localparam int LW     = $clog2(MAX_VL+1);
  localparam int LB     = $clog2(LANES);
  localparam int GROUPS = MAX_VL / LANES;
  localparam int GW     = $clog2(GROUPS);

  logic [ELEM_W-1:0] rf [NREG][MAX_VL];

  logic [RW-1:0]    ra_q, rb_q, rd_q;
  logic [LW-1:0]    vl_q;
  logic             issuing;
  logic [GW-1:0]    grp;
  logic [LANES-1:0] lane_on, s1_v, s2_v;
  logic [GW-1:0]    s1_g, s2_g;
  logic             s1_last, s2_last;
  logic [ELEM_W-1:0] s1_d [LANES];
  logic [ELEM_W-1:0] s2_d [LANES];

  wire            accept   = start && !busy;
  wire [LW-1:0]   vl_in    = (vlen > LW'(MAX_VL)) ? LW'(MAX_VL) : vlen;
  wire [LW:0]     next_base = (LW+1)'({grp, {LB{1'b0}}}) + (LW+1)'(LANES);
  wire            last_grp = next_base >= {1'b0, vl_q};

  assign host_rdata = rf[host_reg][host_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      issuing <= 1'b0;
      grp     <= '0;
      s1_v    <= '0;
      s2_v    <= '0;
      s1_last <= 1'b0;
      s2_last <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ra_q <= src_a;
        rb_q <= src_b;
        rd_q <= dst;
        vl_q <= vl_in;
        grp  <= '0;
        if (vl_in == '0) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          issuing <= 1'b1;
        end
      end else if (issuing) begin
        grp <= grp + 1'b1;
        if (last_grp) issuing <= 1'b0;
      end
      s1_v    <= lane_on;
      s1_g    <= grp;
      s1_last <= issuing && last_grp;
      s2_v    <= s1_v;
      s2_g    <= s1_g;
      s2_last <= s1_last;
      if (s2_last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    wire [IW-1:0] ridx = {grp, LB'(k)};
    assign lane_on[k] = issuing && (LW'(ridx) < vl_q);

    always_ff @(posedge clk) begin
      s1_d[k] <= rf[ra_q][ridx] + rf[rb_q][ridx];
      s2_d[k] <= s1_d[k];
    end

    // R4
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2_v[k] |-> (LW'({s2_g, LB'(k)}) < vl_q));
  end

  always_ff @(posedge clk) begin
    if (host_we && !busy) rf[host_reg][host_idx] <= host_wdata;
    for (int k = 0; k < LANES; k++)
      if (s2_v[k]) rf[rd_q][{s2_g, LB'(k)}] <= s2_d[k];
  end

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen != '0) |=> busy);
  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen == '0) |=> (done && !busy));
  // R8
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vl_q) && $stable(rd_q));
  // R6
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v != '0) |-> busy);
endmodule

// File: tb/vadd4_unit_tb.sv
module vadd4_unit_tb;
  localparam int NREG = 8;
  localparam int MVL  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  src_a = '0, src_b = '0, dst = '0;
  logic [6:0]  vlen = '0;
  logic        busy, done;
  logic        host_we = 1'b0;
  logic [2:0]  host_reg = '0;
  logic [5:0]  host_idx = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;

  logic [63:0] model [NREG][MVL];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vadd4_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
    .dst(dst), .vlen(vlen), .busy(busy), .done(done), .host_we(host_we),
    .host_reg(host_reg), .host_idx(host_idx), .host_wdata(host_wdata),
    .host_rdata(host_rdata));

  function automatic int eff_len(int v);
    return (v > MVL) ? MVL : v;
  endfunction

  function automatic int exp_latency(int l);
    return (l == 0) ? 0 : (l + 3) / 4 + 2;
  endfunction

  task automatic check(bit ok, string tag, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic host_write(int r, int i, logic [63:0] v);
    @(negedge clk);
    host_we = 1'b1; host_reg = 3'(r); host_idx = 6'(i); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    model[r][i] = v;
  endtask

  task automatic compare_all(int d, string dtag);
    for (int r = 0; r < NREG; r++) begin
      bit ok = 1;
      logic [63:0] a = '0, e = '0;
      for (int i = 0; i < MVL; i++) begin
        host_reg = 3'(r); host_idx = 6'(i);
        #1;
        if (ok && host_rdata !== model[r][i]) begin
          ok = 0; a = host_rdata; e = model[r][i];
        end
      end
      check(ok, (r == d) ? dtag : "R10", $sformatf("reg %0d contents", r), a, e);
    end
  endtask

  task automatic run_op(int a, int b, int d, int v, bit poke, string dtag);
    int l = eff_len(v);
    int cyc = 0;
    logic [63:0] sa [MVL];
    logic [63:0] sb [MVL];
    for (int i = 0; i < MVL; i++) begin sa[i] = model[a][i]; sb[i] = model[b][i]; end
    @(negedge clk);
    start = 1'b1; src_a = 3'(a); src_b = 3'(b); dst = 3'(d); vlen = 7'(v);
    @(posedge clk); #1;
    start = 1'b0;
    while (!done && cyc < 200) begin
      check(busy === 1'b1, "R7", "busy during operation", 64'(busy), 1);
      if (poke && cyc == 1) begin
        start = 1'b1; dst = 3'((d + 1) % NREG); vlen = 7'd64;
        host_we = 1'b1; host_reg = 3'((d + 2) % NREG); host_idx = 6'd0;
        host_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      end
      @(posedge clk); #1;
      start = 1'b0; host_we = 1'b0;
      cyc++;
    end
    check(cyc == exp_latency(l), poke ? "R8" : (l == 0 ? "R6" : "R5"),
          $sformatf("done latency for length %0d", l), 64'(cyc), 64'(exp_latency(l)));
    check(busy === 1'b0, "R7", "busy low with done", 64'(busy), 0);
    @(posedge clk); #1;
    check(done === 1'b0, "R7", "done one cycle", 64'(done), 0);
    check(busy === 1'b0, l == 0 ? "R6" : "R7", "idle after done", 64'(busy), 0);
    for (int i = 0; i < l; i++) model[d][i] = sa[i] + sb[i];
    compare_all(d, dtag);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    #1;
    check(busy === 1'b0, "R1", "busy after reset", 64'(busy), 0);
    check(done === 1'b0, "R1", "done after reset", 64'(done), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < MVL; i++)
        host_write(r, i, {$urandom, $urandom});
    compare_all(-1, "R2");

    run_op(0, 1, 2, 64, 0, "R3");
    run_op(1, 2, 3, 0, 0, "R6");
    run_op(3, 4, 5, 1, 0, "R4");
    run_op(5, 6, 7, 5, 0, "R4");
    run_op(0, 7, 6, 63, 0, "R4");
    run_op(2, 3, 4, 100, 0, "R4");
    run_op(4, 5, 4, 37, 0, "R9");
    run_op(6, 6, 6, 64, 0, "R9");
    for (int i = 0; i < MVL; i++) begin
      host_write(0, i, 64'hFFFF_FFFF_FFFF_FFFF - 64'(i));
      host_write(1, i, 64'(i + 1) + 64'(i));
    end
    run_op(0, 1, 2, 64, 0, "R3");
    run_op(3, 2, 5, 64, 1, "R8");
    run_op(7, 1, 0, 22, 1, "R8");
    for (int n = 0; n < 40; n++)
      run_op($urandom % NREG, $urandom % NREG, $urandom % NREG, $urandom % 80, 0, "R3");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule